// File: doc/BRIEF.md
# Load/Store Port Handshake Monitor

This block is a passive observer for one load/store request port. The port sits between a compute unit that issues requests and a memory-side responder that answers them. The monitor samples every port signal on each rising clock edge and drives nothing back onto the port. The handshake is not fire-and-forget: the requester holds the address until the responder releases busy. The responder answers with single-cycle pulses, and the timing of the busy release depends on how the request ends. A load releases busy with the data pulse. A store releases busy one cycle after its data pulse. An exception releases busy on the exception pulse itself.

When the monitor sees a rule broken, it raises a sticky error flag and records a 3-bit code for the first rule broken. Only reset clears the flag and the code. An abort input sends the monitor's tracking back to idle. It records no error for the cycle in which it is high.

The tracking logic is a phase machine with six states:

- `S_IDLE`: no request is outstanding.
- `S_LD_ADDR` and `S_ST_ADDR`: the address is waiting to be accepted.
- `S_LD_DATA`: waiting for the load data pulse.
- `S_ST_DATA`: waiting for the store data pulse.
- `S_ST_DROP`: the cycle after a store data pulse, in which busy must already be low.

The transitions are:

- IDLE to LD_ADDR on a load strobe.
- IDLE to ST_ADDR on a store strobe alone. When both strobes are high, the load takes precedence.
- LD_ADDR or ST_ADDR to IDLE on an exception pulse.
- LD_ADDR to LD_DATA, and ST_ADDR to ST_DATA, on an accept pulse.
- LD_DATA to IDLE on load data, or on an exception.
- ST_DATA to ST_DROP on store data.
- ST_DATA to IDLE on an exception.
- ST_DROP to IDLE unconditionally.
- Any state to IDLE on abort.

Top module: `lsport_monitor`

## Requirements
- R1: After reset, `err_o` is 0 and `err_code_o` is 0.
- R2: A load or store strobe while a request is outstanding (state is LD_ADDR, ST_ADDR, LD_DATA or ST_DATA) and busy is high records code 1.
- R3: Load and store strobes high in the same cycle record code 2.
- R4: During an outstanding request the address is captured on the first cycle its valid flag is high. While busy stays high after that, the valid flag dropping or any address bit changing records code 3.
- R5: Any of the following records code 4:
  - the accept pulse high for two consecutive cycles;
  - the exception pulse high for two consecutive cycles;
  - accept and exception high in the same cycle;
  - an exception after the accept pulse of the same request.
- R6: An exception pulse while busy is high records code 5.
- R7: A load data pulse seen in LD_DATA while busy is high records code 6, and so does a load data pulse high for two consecutive cycles.
- R8: Code 7 is recorded when:
  - a store data pulse arrives in any state other than ST_DATA (so before the accept pulse, or held for two cycles);
  - busy is high in the cycle after the store data pulse.
- R9: Legal load, store and exception sequences leave `err_o` at 0. This holds for any address, any wait before the accept pulse, any wait before the data pulse, and whether the address is valid on the request cycle or one cycle later.
- R10: Once `err_o` is set it stays set and `err_code_o` keeps the first code until reset. When several rules break in one cycle, the lowest code is recorded.
- R11: In a cycle with `abort_i` high no error is recorded, and tracking returns to IDLE. A following request therefore starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_i | input | 1 | Returns tracking to idle, suppresses errors this cycle |
| ld_req_i | input | 1 | Load request strobe |
| st_req_i | input | 1 | Store request strobe |
| addr_vld_i | input | 1 | Address valid flag from requester |
| addr_i | input | ADDR_W | Request address |
| busy_i | input | 1 | Port busy, driven by responder |
| addr_acc_i | input | 1 | Address accepted pulse |
| addr_exc_i | input | 1 | Address exception pulse |
| ld_vld_i | input | 1 | Load data valid pulse |
| st_vld_i | input | 1 | Store data valid pulse |
| err_o | output | 1 | Sticky violation flag |
| err_code_o | output | 3 | Code of first violation (0 when none) |

## Verification
The bench builds the monitor with `ADDR_W` set to 4. At that width a legal sweep covers all 16 addresses, crossed with every accept wait and data wait from 0 to 2 cycles and with early and late address valid. Every single-bit address change can also be tried one by one. Each violation class is then provoked separately, and the expected code is computed from the numbering in the requirements. Two extra cases cover the lowest-code rule when two violations coincide, and show that a later violation leaves the first code in place.

// File: rtl/lsmon_pkg.sv
package lsmon_pkg;
    localparam int NCODE  = 7;
    localparam int CODE_W = $clog2(NCODE + 1);

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_LD_ADDR = 3'd1,
        S_LD_DATA = 3'd2,
        S_ST_ADDR = 3'd3,
        S_ST_DATA = 3'd4,
        S_ST_DROP = 3'd5
    } phase_t;

    // error numbering: lower value wins when several rules break together
    localparam logic [CODE_W-1:0] E_REQ_BUSY  = 3'd1;
    localparam logic [CODE_W-1:0] E_DUAL_REQ  = 3'd2;
    localparam logic [CODE_W-1:0] E_ADDR_MOVE = 3'd3;
    localparam logic [CODE_W-1:0] E_ADDR_RESP = 3'd4;
    localparam logic [CODE_W-1:0] E_EXC_BUSY  = 3'd5;
    localparam logic [CODE_W-1:0] E_LD_DONE   = 3'd6;
    localparam logic [CODE_W-1:0] E_ST_DONE   = 3'd7;
endpackage

// File: rtl/lsmon_pulse.sv
module lsmon_pulse #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pulse_i,
    output logic [W-1:0] held_o
);
    logic [W-1:0] last_q;

    for (genvar g = 0; g < W; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) last_q[g] <= 1'b0;
            else        last_q[g] <= pulse_i[g];
        end
        assign held_o[g] = pulse_i[g] & last_q[g];

        // a lane can only report "held" when it was high on the previous edge
        assert_lane_prev_R5: assert property (@(posedge clk) disable iff (!rst_n)
            held_o[g] |-> $past(pulse_i[g]));
    end
endmodule

// File: rtl/lsmon_fsm.sv
module lsmon_fsm
    import lsmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic abort_i,
    input  logic ld_req_i,
    input  logic st_req_i,
    input  logic busy_i,
    input  logic addr_acc_i,
    input  logic addr_exc_i,
    input  logic ld_vld_i,
    input  logic st_vld_i,
    output logic v_req_o,
    output logic v_dual_o,
    output logic v_resp_o,
    output logic v_exc_o,
    output logic v_ld_o,
    output logic v_st_o,
    output logic hold_chk_o,
    output logic track_o,
    output logic new_op_o
);
    phase_t state_q, state_n;
    logic   any_req;

    assign any_req = ld_req_i | st_req_i;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n  = state_q;
        new_op_o = 1'b0;
        v_req_o  = 1'b0;
        v_dual_o = ld_req_i & st_req_i;
        v_exc_o  = addr_exc_i & busy_i;
        v_resp_o = addr_acc_i & addr_exc_i;
        v_ld_o   = 1'b0;
        v_st_o   = st_vld_i & (state_q != S_ST_DATA);
        unique case (state_q)
            S_IDLE: begin
                if (any_req) begin
                    new_op_o = 1'b1;
                    state_n  = ld_req_i ? S_LD_ADDR : S_ST_ADDR;
                end
            end
            S_LD_ADDR, S_ST_ADDR: begin
                v_req_o = any_req & busy_i;
                if (addr_exc_i)
                    state_n = S_IDLE;
                else if (addr_acc_i)
                    state_n = (state_q == S_LD_ADDR) ? S_LD_DATA : S_ST_DATA;
            end
            S_LD_DATA: begin
                v_req_o = any_req & busy_i;
                if (addr_exc_i) begin
                    v_resp_o = 1'b1;
                    state_n  = S_IDLE;
                end else if (ld_vld_i) begin
                    v_ld_o  = busy_i;
                    state_n = S_IDLE;
                end
            end
            S_ST_DATA: begin
                v_req_o = any_req & busy_i;
                if (addr_exc_i) begin
                    v_resp_o = 1'b1;
                    state_n  = S_IDLE;
                end else if (st_vld_i) begin
                    state_n = S_ST_DROP;
                end
            end
            S_ST_DROP: begin
                v_st_o  = v_st_o | busy_i;
                state_n = S_IDLE;
            end
            default: state_n = S_IDLE;
        endcase
        if (abort_i) begin
            state_n  = S_IDLE;
            new_op_o = 1'b0;
            v_req_o  = 1'b0;
            v_dual_o = 1'b0;
            v_resp_o = 1'b0;
            v_exc_o  = 1'b0;
            v_ld_o   = 1'b0;
            v_st_o   = 1'b0;
        end
    end

    assign track_o    = (state_n != S_IDLE);
    assign hold_chk_o = (state_q == S_LD_ADDR) || (state_q == S_ST_ADDR) ||
                        (state_q == S_LD_DATA) || (state_q == S_ST_DATA);

    assert_drop_follows_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ST_DROP) |-> $past(st_vld_i));
    assert_abort_to_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (state_q == S_IDLE));
    assert_data_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_LD_DATA) || (state_q == S_ST_DATA)) |-> $past(addr_acc_i) ||
        $stable(state_q));
endmodule

// File: rtl/lsmon_addr.sv
module lsmon_addr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              track_i,
    input  logic              new_op_i,
    input  logic              hold_chk_i,
    input  logic              busy_i,
    input  logic              addr_vld_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              v_move_o
);
    logic              held_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            addr_q <= '0;
        end else if (!track_i) begin
            held_q <= 1'b0;
        end else if (new_op_i) begin
            held_q <= addr_vld_i;
            addr_q <= addr_i;
        end else if (!held_q && addr_vld_i) begin
            held_q <= 1'b1;
            addr_q <= addr_i;
        end
    end

    assign v_move_o = hold_chk_i & held_q & busy_i &
                      (!addr_vld_i || (addr_i != addr_q));

    assert_capture_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (new_op_i && track_i && addr_vld_i) |=> held_q);
    assert_release_on_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !track_i |=> !held_q);
endmodule

// File: rtl/lsmon_errlatch.sv
module lsmon_errlatch
    import lsmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_i,
    input  logic [NCODE:1]    viol_i,
    output logic              err_o,
    output logic [CODE_W-1:0] code_o
);
    logic [CODE_W-1:0] first;

    always_comb begin
        first = '0;
        for (int k = NCODE; k >= 1; k--)
            if (viol_i[k]) first = CODE_W'(k);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o  <= 1'b0;
            code_o <= '0;
        end else if (!err_o && !abort_i && (first != '0)) begin
            err_o  <= 1'b1;
            code_o <= first;
        end
    end

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
    assert_code_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> $stable(code_o));
    assert_abort_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !err_o) |=> !err_o);
endmodule

// File: rtl/lsport_monitor.sv
module lsport_monitor
    import lsmon_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_i,
    input  logic              ld_req_i,
    input  logic              st_req_i,
    input  logic              addr_vld_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              busy_i,
    input  logic              addr_acc_i,
    input  logic              addr_exc_i,
    input  logic              ld_vld_i,
    input  logic              st_vld_i,
    output logic              err_o,
    output logic [2:0]        err_code_o
);
    localparam int NLANE = 4;

    logic v_req, v_dual, v_resp, v_exc, v_ld, v_st, v_move;
    logic hold_chk, track, new_op;
    logic [NLANE-1:0] lanes, held;
    logic [NCODE:1]   viol;

    lsmon_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort_i    (abort_i),
        .ld_req_i   (ld_req_i),
        .st_req_i   (st_req_i),
        .busy_i     (busy_i),
        .addr_acc_i (addr_acc_i),
        .addr_exc_i (addr_exc_i),
        .ld_vld_i   (ld_vld_i),
        .st_vld_i   (st_vld_i),
        .v_req_o    (v_req),
        .v_dual_o   (v_dual),
        .v_resp_o   (v_resp),
        .v_exc_o    (v_exc),
        .v_ld_o     (v_ld),
        .v_st_o     (v_st),
        .hold_chk_o (hold_chk),
        .track_o    (track),
        .new_op_o   (new_op)
    );

    lsmon_addr #(.ADDR_W(ADDR_W)) i_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .track_i    (track),
        .new_op_i   (new_op),
        .hold_chk_i (hold_chk),
        .busy_i     (busy_i),
        .addr_vld_i (addr_vld_i),
        .addr_i     (addr_i),
        .v_move_o   (v_move)
    );

    // lane order: 0 accept, 1 exception, 2 load data, 3 store data
    assign lanes = {st_vld_i, ld_vld_i, addr_exc_i, addr_acc_i};

    lsmon_pulse #(.W(NLANE)) i_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (lanes),
        .held_o  (held)
    );

    assign viol[1] = v_req;
    assign viol[2] = v_dual;
    assign viol[3] = v_move;
    assign viol[4] = v_resp | held[0] | held[1];
    assign viol[5] = v_exc;
    assign viol[6] = v_ld | held[2];
    assign viol[7] = v_st | held[3];

    lsmon_errlatch i_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort_i (abort_i),
        .viol_i  (viol),
        .err_o   (err_o),
        .code_o  (err_code_o)
    );

    assert_dual_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req_i && st_req_i && !abort_i) |=> err_o);
    assert_acc_exc_clash_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_acc_i && addr_exc_i && !abort_i) |=> err_o);
    assert_exc_with_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_exc_i && busy_i && !abort_i) |=> err_o);
    assert_ld_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_vld_i && $past(ld_vld_i) && !abort_i) |=> err_o);
endmodule

// File: tb/test_lsport_monitor.sv
module test_lsport_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n, abort_i, ld_req_i, st_req_i, addr_vld_i, busy_i;
    logic addr_acc_i, addr_exc_i, ld_vld_i, st_vld_i;
    logic [AW-1:0] addr_i;
    logic err_o;
    logic [2:0] err_code_o;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lsport_monitor #(.ADDR_W(AW)) i_lsport_monitor (
        .clk(clk), .rst_n(rst_n), .abort_i(abort_i),
        .ld_req_i(ld_req_i), .st_req_i(st_req_i),
        .addr_vld_i(addr_vld_i), .addr_i(addr_i), .busy_i(busy_i),
        .addr_acc_i(addr_acc_i), .addr_exc_i(addr_exc_i),
        .ld_vld_i(ld_vld_i), .st_vld_i(st_vld_i),
        .err_o(err_o), .err_code_o(err_code_o)
    );

    // apply one cycle of port values, return at the following falling edge
    task automatic drv(input bit ld, input bit st, input bit av, input logic [AW-1:0] a,
                       input bit bz, input bit ac, input bit ex, input bit lv,
                       input bit sv, input bit ab);
        ld_req_i = ld; st_req_i = st; addr_vld_i = av; addr_i = a; busy_i = bz;
        addr_acc_i = ac; addr_exc_i = ex; ld_vld_i = lv; st_vld_i = sv; abort_i = ab;
        @(negedge clk);
    endtask

    task automatic idle();
        drv(0, 0, 0, '0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(); idle();
        rst_n = 1'b1;
        idle();
    endtask

    task automatic chk(input string req, input bit exp_err, input logic [2:0] exp_code);
        n_run++;
        if (err_o !== exp_err || err_code_o !== exp_code) begin
            n_fail++;
            $display("FAIL %s: err=%0b code=%0d expected err=%0b code=%0d",
                     req, err_o, err_code_o, exp_err, exp_code);
        end
    endtask

    task automatic legal_load(input logic [AW-1:0] a, input int wa, input int wd, input bit late);
        drv(1, 0, !late, a, 1, 0, 0, 0, 0, 0);
        if (late) drv(0, 0, 1, a, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < wa; i++) drv(0, 0, 1, a, 1, 0, 0, 0, 0, 0);
        drv(0, 0, 1, a, 1, 1, 0, 0, 0, 0);
        for (int i = 0; i < wd; i++) drv(0, 0, 1, a, 1, 0, 0, 0, 0, 0);
        drv(0, 0, 1, a, 0, 0, 0, 1, 0, 0);
        idle();
    endtask

    task automatic legal_store(input logic [AW-1:0] a, input int wa, input int wd, input bit late);
        drv(0, 1, !late, a, 1, 0, 0, 0, 0, 0);
        if (late) drv(0, 0, 1, a, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < wa; i++) drv(0, 0, 1, a, 1, 0, 0, 0, 0, 0);
        drv(0, 0, 1, a, 1, 1, 0, 0, 0, 0);
        for (int i = 0; i < wd; i++) drv(0, 0, 1, a, 1, 0, 0, 0, 0, 0);
        drv(0, 0, 1, a, 1, 0, 0, 0, 1, 0);
        drv(0, 0, 0, a, 0, 0, 0, 0, 0, 0);
        idle();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0;
        idle();
        do_reset();
        chk("R1 reset state", 0, 3'd0);

        // R9: legal sweeps
        for (int a = 0; a < 16; a++)
            for (int wa = 0; wa < 3; wa++)
                for (int wd = 0; wd < 3; wd++)
                    for (int lt = 0; lt < 2; lt++) begin
                        legal_load(AW'(a), wa, wd, lt[0]);
                        chk("R9 legal load", 0, 3'd0);
                        legal_store(AW'(a), wa, wd, lt[0]);
                        chk("R9 legal store", 0, 3'd0);
                    end
        for (int a = 0; a < 16; a++)
            for (int wa = 0; wa < 3; wa++) begin
                drv(a[0], !a[0], 1, AW'(a), 1, 0, 0, 0, 0, 0);
                for (int i = 0; i < wa; i++) drv(0, 0, 1, AW'(a), 1, 0, 0, 0, 0, 0);
                drv(0, 0, 1, AW'(a), 0, 0, 1, 0, 0, 0);
                idle();
                chk("R9 legal exception", 0, 3'd0);
            end

        // R2: strobe while outstanding and busy
        do_reset();
        drv(1, 0, 1, 4'h3, 1, 0, 0, 0, 0, 0);
        drv(1, 0, 1, 4'h3, 1, 0, 0, 0, 0, 0);
        chk("R2 request while busy", 1, 3'd1);

        // R3: both strobes from idle
        do_reset();
        drv(1, 1, 1, 4'h3, 1, 0, 0, 0, 0, 0);
        chk("R3 dual strobe", 1, 3'd2);

        // R4: every single address bit changed, and valid dropped
        for (int b = 0; b < AW; b++) begin
            do_reset();
            drv(1, 0, 1, 4'h5, 1, 0, 0, 0, 0, 0);
            drv(0, 0, 1, 4'h5 ^ AW'(1 << b), 1, 0, 0, 0, 0, 0);
            chk("R4 address bit moved", 1, 3'd3);
        end
        do_reset();
        drv(0, 1, 1, 4'ha, 1, 0, 0, 0, 0, 0);
        drv(0, 0, 1, 4'ha, 1, 1, 0, 0, 0, 0);
        drv(0, 0, 0, 4'ha, 1, 0, 0, 0, 0, 0);
        chk("R4 valid dropped", 1, 3'd3);

        // R5 variants
        do_reset();
        drv(1, 0, 1, 4'h1, 1, 0, 0, 0, 0, 0);
        drv(0, 0, 1, 4'h1, 1, 1, 0, 0, 0, 0);
        drv(0, 0, 1, 4'h1, 1, 1, 0, 0, 0, 0);
        chk("R5 accept held", 1, 3'd4);
        do_reset();
        drv(1, 0, 1, 4'h1, 1, 0, 0, 0, 0, 0);
        drv(0, 0, 1, 4'h1, 0, 0, 1, 0, 0, 0);
        drv(0, 0, 0, 4'h1, 0, 0, 1, 0, 0, 0);
        chk("R5 exception held", 1, 3'd4);
        do_reset();
        drv(1, 0, 1, 4'h1, 1, 0, 0, 0, 0, 0);
        drv(0, 0, 1, 4'h1, 0, 1, 1, 0, 0, 0);
        chk("R5 accept with exception", 1, 3'd4);
        do_reset();
        drv(0, 1, 1, 4'h1, 1, 0, 0, 0, 0, 0);
        drv(0, 0, 1, 4'h1, 1, 1, 0, 0, 0, 0);
        drv(0, 0, 1, 4'h1, 0, 0, 1, 0, 0, 0);
        chk("R5 exception after accept", 1, 3'd4);

        // R6
        do_reset();
        drv(1, 0, 1, 4'h2, 1, 0, 0, 0, 0, 0);
        drv(0, 0, 1, 4'h2, 1, 0, 1, 0, 0, 0);
        chk("R6 exception with busy", 1, 3'd5);

        // R7
        do_reset();
        drv(1, 0, 1, 4'h2, 1, 0, 0, 0, 0, 0);
        drv(0, 0, 1, 4'h2, 1, 1, 0, 0, 0, 0);
        drv(0, 0, 1, 4'h2, 1, 0, 0, 1, 0, 0);
        chk("R7 load data with busy", 1, 3'd6);
        do_reset();
        drv(1, 0, 1, 4'h2, 1, 0, 0, 0, 0, 0);
        drv(0, 0, 1, 4'h2, 1, 1, 0, 0, 0, 0);
        drv(0, 0, 1, 4'h2, 0, 0, 0, 1, 0, 0);
        drv(0, 0, 0, 4'h2, 0, 0, 0, 1, 0, 0);
        chk("R7 load data held", 1, 3'd6);

        // R8
        do_reset();
        drv(0, 1, 1, 4'h6, 1, 0, 0, 0, 0, 0);
        drv(0, 0, 1, 4'h6, 1, 0, 0, 0, 1, 0);
        chk("R8 store data before accept", 1, 3'd7);
        do_reset();
        drv(0, 1, 1, 4'h6, 1, 0, 0, 0, 0, 0);
        drv(0, 0, 1, 4'h6, 1, 1, 0, 0, 0, 0);
        drv(0, 0, 1, 4'h6, 1, 0, 0, 0, 1, 0);
        drv(0, 0, 0, 4'h6, 0, 0, 0, 0, 1, 0);
        chk("R8 store data held", 1, 3'd7);
        do_reset();
        drv(0, 1, 1, 4'h6, 1, 0, 0, 0, 0, 0);
        drv(0, 0, 1, 4'h6, 1, 1, 0, 0, 0, 0);
        drv(0, 0, 1, 4'h6, 1, 0, 0, 0, 1, 0);
        chk("R8 no error on store data cycle", 0, 3'd0);
        drv(0, 0, 1, 4'h6, 1, 0, 0, 0, 0, 0);
        chk("R8 busy kept after store", 1, 3'd7);

        // R10: lowest code wins, first code is kept
        do_reset();
        drv(1, 0, 1, 4'h7, 1, 0, 0, 0, 0, 0);
        drv(1, 1, 1, 4'h7, 1, 0, 0, 0, 0, 0);
        chk("R10 lowest code same cycle", 1, 3'd1);
        do_reset();
        drv(1, 0, 1, 4'h7, 1, 0, 0, 0, 0, 0);
        drv(0, 0, 1, 4'h8, 1, 0, 0, 0, 0, 0);
        drv(1, 1, 1, 4'h8, 1, 0, 0, 0, 0, 0);
        idle(); idle();
        chk("R10 first code retained", 1, 3'd3);

        // R11: abort suppresses and restarts tracking
        do_reset();
        drv(1, 0, 1, 4'h3, 1, 0, 0, 0, 0, 0);
        drv(0, 0, 1, 4'hc, 1, 0, 1, 0, 0, 1);
        chk("R11 violation masked by abort", 0, 3'd0);
        drv(1, 0, 1, 4'h9, 1, 0, 0, 0, 0, 0);
        drv(0, 0, 1, 4'h9, 1, 1, 0, 0, 0, 0);
        drv(0, 0, 1, 4'h9, 0, 0, 0, 1, 0, 0);
        idle();
        chk("R11 fresh request after abort", 0, 3'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule